// File: doc/BRIEF.md
# Three-Phase Waveform Capture with Data-Ready Interrupt

This block keeps the most recent phase A, B and C voltage samples from a free-running 24-bit sample stream and, on each capture tick (nominally 8 kHz), copies that triple into three waveform registers in one clock cycle. Each capture raises a data-ready flag. The flag drives an active-low interrupt line when the matching mask bit is set. Software reads the waveform registers as 32-bit words, sign-extended so that a 32-bit serial transfer carries the sample unchanged. It clears the flag by writing a one to it.

The sample input has no back-pressure. A valid strobe is always accepted, and capturing never holds up the stream. The capture tick comes either from an input pin or from an internal divider of the system clock. A parameter selects which.

Top module: `wc_wave_capture`

## Requirements
- R1: After reset the waveform words, the status word and the mask word all read 0, and irq_no is 1.
- R2: A capture tick copies the latest valid A, B and C samples into the waveform outputs together. All three outputs change in the cycle after the tick edge.
- R3: Without a capture tick the waveform outputs keep their value, even while new valid samples arrive.
- R4: Reads at address 0, 1 and 2 return the A, B and C waveform words. Each word is the 24-bit sample sign-extended from bit 23 to 32 bits.
- R5: Status bit 17 (data ready, read at address 3) reads 1 in the cycle after any capture.
- R6: A write to address 3 with bit 17 set clears status bit 17. A write to address 3 with bit 17 clear leaves it unchanged.
- R7: When a capture and a clearing write fall in the same cycle, status bit 17 stays 1.
- R8: Mask bit 17 is written and read at address 4. All other mask bits always read 0.
- R9: irq_no is 0 exactly while status bit 17 and mask bit 17 are both 1. It follows them without added delay.
- R10: If a valid sample arrives in the same cycle as the capture tick, that new sample is captured, not the one held before it.
- R11: With the internal divider selected (USE_EXT_TICK=0), a capture happens every TICK_DIV clock cycles. Captures of an incrementing sample stream therefore differ by TICK_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_a_i | input | SMP_W | Phase A sample, signed |
| smp_b_i | input | SMP_W | Phase B sample, signed |
| smp_c_i | input | SMP_W | Phase C sample, signed |
| smp_valid_i | input | 1 | Sample triple valid strobe |
| tick_i | input | 1 | External capture tick (used when USE_EXT_TICK=1) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | WORD_W | Register write data |
| reg_rdata_o | output | WORD_W | Read data for reg_addr_i |
| wave_a_o | output | WORD_W | Phase A waveform word, sign-extended |
| wave_b_o | output | WORD_W | Phase B waveform word, sign-extended |
| wave_c_o | output | WORD_W | Phase C waveform word, sign-extended |
| status_o | output | WORD_W | Status word, data-ready at bit 17 |
| mask_o | output | WORD_W | Mask word, enable at bit 17 |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Corrupt staging or held sample registers show up at the waveform ports one cycle after the next tick. A lane updated out of step shows up as a mixed triple in the same readout. A stuck or wrongly prioritised data-ready flag appears on status_o in the cycle after the tick or clearing write, and irq_no reflects it in that same cycle. A wrong divider count shows up as sample-to-sample steps other than TICK_DIV within three capture periods.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DRDY_BIT = 17;
  localparam int unsigned N_PH     = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_WAVE_A = 3'd0,
    RA_WAVE_B = 3'd1,
    RA_WAVE_C = 3'd2,
    RA_STATUS = 3'd3,
    RA_MASK   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/wc_tick_gen.sv
module wc_tick_gen #(
  parameter bit          USE_EXT = 1'b1,
  parameter int unsigned DIV     = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (USE_EXT) begin : g_ext
      assign tick_o = tick_i;
    end else begin : g_div
      logic [CNT_W-1:0] cnt_q;
      logic             wrap;
      logic             unused_tick;
      assign unused_tick = tick_i;
      assign wrap   = (cnt_q == CNT_W'(DIV - 1));
      assign tick_o = wrap;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wc_sample_bank.sv
module wc_sample_bank #(
  parameter int unsigned SMP_W = 24,
  parameter int unsigned N     = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0][SMP_W-1:0]   smp_i,
  input  logic                      valid_i,
  input  logic                      cap_i,
  output logic [N-1:0][SMP_W-1:0]   held_o
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_lane
      logic [SMP_W-1:0] stage_q;
      logic [SMP_W-1:0] held_q;
      logic [SMP_W-1:0] cap_val;
      // a sample arriving with the tick is newer than the staged one
      assign cap_val = valid_i ? smp_i[g] : stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stage_q <= '0;
          held_q  <= '0;
        end else begin
          if (valid_i) stage_q <= smp_i[g];
          if (cap_i)   held_q  <= cap_val;
        end
      end
      assign held_o[g] = held_q;
    end
  endgenerate
endmodule

// File: rtl/wc_irq_regs.sv
module wc_irq_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic clr_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  output logic flag_o,
  output logic mask_o,
  output logic irq_no
);
  logic flag_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (cap_i)      flag_q <= 1'b1;   // capture beats clear
      else if (clr_i) flag_q <= 1'b0;
      if (mask_we_i)  mask_q <= mask_d_i;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_no = ~(flag_q & mask_q);
endmodule

// File: rtl/wc_wave_capture.sv
module wc_wave_capture
  import wc_pkg::*;
#(
  parameter int unsigned SMP_W        = 24,
  parameter int unsigned WORD_W       = 32,
  parameter bit          USE_EXT_TICK = 1'b1,
  parameter int unsigned TICK_DIV     = 12500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SMP_W-1:0]  smp_a_i,
  input  logic [SMP_W-1:0]  smp_b_i,
  input  logic [SMP_W-1:0]  smp_c_i,
  input  logic              smp_valid_i,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [WORD_W-1:0] wave_a_o,
  output logic [WORD_W-1:0] wave_b_o,
  output logic [WORD_W-1:0] wave_c_o,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] mask_o,
  output logic              irq_no
);
  localparam int unsigned EXT_W = WORD_W - SMP_W;

  logic                          cap;
  logic [N_PH-1:0][SMP_W-1:0]    smp_in;
  logic [N_PH-1:0][SMP_W-1:0]    held;
  logic [N_PH-1:0][WORD_W-1:0]   word;
  logic                          flag, mask_bit;
  logic                          st_clr, mask_we;
  logic                          unused_wdata;

  wc_tick_gen #(.USE_EXT(USE_EXT_TICK), .DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_i, .tick_o(cap)
  );

  assign smp_in = {smp_c_i, smp_b_i, smp_a_i};

  wc_sample_bank #(.SMP_W(SMP_W), .N(N_PH)) u_bank (
    .clk_i, .rst_ni, .smp_i(smp_in), .valid_i(smp_valid_i),
    .cap_i(cap), .held_o(held)
  );

  generate
    for (genvar g = 0; g < N_PH; g++) begin : g_sext
      assign word[g] = {{EXT_W{held[g][SMP_W-1]}}, held[g]};
    end
  endgenerate

  assign wave_a_o = word[0];
  assign wave_b_o = word[1];
  assign wave_c_o = word[2];

  assign st_clr  = reg_wr_i && (reg_addr_i == RA_STATUS) && reg_wdata_i[DRDY_BIT];
  assign mask_we = reg_wr_i && (reg_addr_i == RA_MASK);
  assign unused_wdata = ^{reg_wdata_i[WORD_W-1:DRDY_BIT+1], reg_wdata_i[DRDY_BIT-1:0]};

  wc_irq_regs u_irq (
    .clk_i, .rst_ni, .cap_i(cap), .clr_i(st_clr),
    .mask_we_i(mask_we), .mask_d_i(reg_wdata_i[DRDY_BIT]),
    .flag_o(flag), .mask_o(mask_bit), .irq_no
  );

  always_comb begin
    status_o = '0;
    mask_o   = '0;
    status_o[DRDY_BIT] = flag;
    mask_o[DRDY_BIT]   = mask_bit;
  end

  always_comb begin
    case (reg_addr_i)
      RA_WAVE_A: reg_rdata_o = word[0];
      RA_WAVE_B: reg_rdata_o = word[1];
      RA_WAVE_C: reg_rdata_o = word[2];
      RA_STATUS: reg_rdata_o = status_o;
      RA_MASK:   reg_rdata_o = mask_o;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wc_wave_capture_chk.sv
module wc_wave_capture_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cap,
  input logic              reg_wr_i,
  input logic [2:0]        reg_addr_i,
  input logic [WORD_W-1:0] reg_wdata_i,
  input logic [WORD_W-1:0] wave_a_o,
  input logic [WORD_W-1:0] wave_b_o,
  input logic [WORD_W-1:0] wave_c_o,
  input logic [WORD_W-1:0] status_o,
  input logic [WORD_W-1:0] mask_o,
  input logic              irq_no
);
  localparam int unsigned DB = 17;

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> ($stable(wave_a_o) && $stable(wave_b_o) && $stable(wave_c_o))); // R3

  AST_READY_AFTER_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> status_o[DB]); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd3 && reg_wdata_i[DB] && !cap) |=> !status_o[DB]); // R6

  AST_CAPTURE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd3 && reg_wdata_i[DB] && cap) |=> status_o[DB]); // R7

  AST_MASK_ONLY_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mask_o) <= 1 && $onehot0(status_o)); // R8

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_o[DB] |-> irq_no); // R9

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> ($rose(status_o[DB]) || $rose(mask_o[DB]))); // R9
endmodule

bind wc_wave_capture wc_wave_capture_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cap(cap), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .wave_a_o(wave_a_o), .wave_b_o(wave_b_o), .wave_c_o(wave_c_o),
  .status_o(status_o), .mask_o(mask_o), .irq_no(irq_no)
);

// File: tb/wc_wave_capture_test.sv
`timescale 1ns/1ps
module wc_wave_capture_test;
  localparam int DIVN = 8;
  localparam logic [31:0] DRDY = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] sa = '0, sb = '0, sc = '0;
  logic        sv = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, wa, wb, wc, st, mk;
  logic        irq_n;

  logic [23:0] da = '0;
  logic [31:0] d_rdata, d_wa, d_wb, d_wc, d_st, d_mk;
  logic        d_irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wc_wave_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_a_i(sa), .smp_b_i(sb), .smp_c_i(sc),
    .smp_valid_i(sv), .tick_i(tick), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wave_a_o(wa), .wave_b_o(wb),
    .wave_c_o(wc), .status_o(st), .mask_o(mk), .irq_no(irq_n)
  );

  wc_wave_capture #(.USE_EXT_TICK(1'b0), .TICK_DIV(DIVN)) uut_div (
    .clk_i(clk), .rst_ni(rst_n), .smp_a_i(da), .smp_b_i(24'h0), .smp_c_i(24'h0),
    .smp_valid_i(rst_n), .tick_i(1'b0), .reg_wr_i(1'b0), .reg_addr_i(3'd0),
    .reg_wdata_i(32'h0), .reg_rdata_o(d_rdata), .wave_a_o(d_wa), .wave_b_o(d_wb),
    .wave_c_o(d_wc), .status_o(d_st), .mask_o(d_mk), .irq_no(d_irq)
  );

  initial forever begin
    @(negedge clk);
    if (rst_n) da = da + 24'd1;
  end

  function automatic logic [31:0] sx(input logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic stage(input logic [23:0] a, input logic [23:0] b, input logic [23:0] c);
    @(negedge clk); sa = a; sb = b; sc = c; sv = 1'b1;
    @(negedge clk); sv = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 wave_a", wa, 32'h0);
    chk("R1 wave_b", wb, 32'h0);
    chk("R1 wave_c", wc, 32'h0);
    chk("R1 status", st, 32'h0);
    chk("R1 mask", mk, 32'h0);
    chk("R1 irq_no", {31'h0, irq_n}, 32'h1);
  endtask

  task automatic t_capture();
    stage(24'h123456, 24'h654321, 24'h0ABCDE);
    chk("R3 no tick keeps wave_a", wa, 32'h0);
    chk("R5 no ready before tick", st, 32'h0);
    pulse_tick();
    chk("R2 wave_a", wa, 32'h0012_3456);
    chk("R2 wave_b", wb, 32'h0065_4321);
    chk("R2 wave_c", wc, 32'h000A_BCDE);
    chk("R5 ready set", st, DRDY);
  endtask

  task automatic t_no_tick();
    stage(24'h111111, 24'h222222, 24'h333333);
    repeat (3) @(negedge clk);
    chk("R3 wave_a held", wa, 32'h0012_3456);
    chk("R3 wave_c held", wc, 32'h000A_BCDE);
  endtask

  task automatic t_sign_ext();
    logic [31:0] r;
    stage(24'h800001, 24'h7FFFFF, 24'hFFFFFF);
    pulse_tick();
    rd_reg(3'd0, r); chk("R4 read A", r, sx(24'h800001));
    rd_reg(3'd1, r); chk("R4 read B", r, sx(24'h7FFFFF));
    rd_reg(3'd2, r); chk("R4 read C", r, sx(24'hFFFFFF));
    rd_reg(3'd3, r); chk("R4 read status", r, DRDY);
  endtask

  task automatic t_clear();
    wr_reg(3'd3, ~DRDY);
    chk("R6 zero bit no clear", st, DRDY);
    wr_reg(3'd3, DRDY);
    chk("R6 w1c clears", st, 32'h0);
  endtask

  task automatic t_clash();
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 3'd3; wdata = DRDY;
    @(negedge clk); tick = 1'b0; wr = 1'b0; wdata = '0;
    chk("R7 capture beats clear", st, DRDY);
  endtask

  task automatic t_mask_irq();
    logic [31:0] r;
    chk("R9 masked irq high", {31'h0, irq_n}, 32'h1);
    wr_reg(3'd4, 32'hFFFF_FFFF);
    rd_reg(3'd4, r); chk("R8 mask readback", r, DRDY);
    chk("R9 irq low", {31'h0, irq_n}, 32'h0);
    wr_reg(3'd3, DRDY);
    chk("R9 irq released on clear", {31'h0, irq_n}, 32'h1);
    pulse_tick();
    chk("R9 irq low on capture", {31'h0, irq_n}, 32'h0);
    wr_reg(3'd4, 32'h0);
    chk("R8 mask cleared", mk, 32'h0);
    chk("R9 irq high when unmasked", {31'h0, irq_n}, 32'h1);
  endtask

  task automatic t_bypass();
    stage(24'h0AAAAA, 24'h0BBBBB, 24'h0CCCCC);
    @(negedge clk); sa = 24'h0DDDDD; sb = 24'h0EEEEE; sc = 24'hF00001; sv = 1'b1; tick = 1'b1;
    @(negedge clk); sv = 1'b0; tick = 1'b0;
    chk("R10 bypass A", wa, 32'h000D_DDDD);
    chk("R10 bypass B", wb, 32'h000E_EEEE);
    chk("R10 bypass C", wc, sx(24'hF00001));
  endtask

  task automatic t_divider();
    logic [31:0] prev, v1, v2, v3;
    prev = d_wa;
    @(negedge clk);
    while (d_wa == prev) begin prev = d_wa; @(negedge clk); end
    v1 = d_wa; prev = v1;
    while (d_wa == prev) @(negedge clk);
    v2 = d_wa; prev = v2;
    while (d_wa == prev) @(negedge clk);
    v3 = d_wa;
    chk("R11 divider step 1", v2 - v1, DIVN);
    chk("R11 divider step 2", v3 - v2, DIVN);
    chk("R11 ready flag", d_st, DRDY);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_no_tick();
    t_sign_ext();
    t_clear();
    t_clash();
    t_mask_irq();
    t_bypass();
    t_divider();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-scope actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule